// File: doc/BRIEF.md
# Two-Group Prioritised Bus Arbiter

This block decides which agent may drive a shared parallel bus next. It serves up to nine external requesters plus the local master port of the bridge that contains it. A configuration mask places each agent in either a high group or a low group. The high group is served in round-robin order. The low group as a whole takes one extra position in that rotation, and its members rotate among themselves whenever that position comes up. Requests and grants are active-low. Grants are one-hot, and they are registered so they can go straight to pins.

A new decision is taken only at an arbitration point, which is any cycle in which `frame_n` is high. That covers both an idle bus and a master that has started its last data phase. Between arbitration points the grant is held. A grant that has been taken away stays off for a minimum gap before the same agent can receive it again.

When nobody is requesting, the bus can be parked on the local master. The block raises `own_drive` when the local master is granted on an idle bus, and in that state the local master must drive the address, command and parity lines.

Top module: `arb2_top`

## Requirements
- R1: At most one bit of `gnt_n` is low in any cycle.
- R2: When `frame_n` is sampled low at a clock edge, `gnt_n` does not change at that edge.
- R3: At an arbitration point, the high-group search begins at the agent after the one last granted through the high rotation, then wraps around. Agent index i is `req_n[i]` for i<9, and index 9 is the local master.
- R4: The whole low group fills position 10 of the high rotation, which is the position after index 9. When that position wins, the low member granted is the first requesting member after the last low member granted.
- R5: After an agent's grant is deasserted, the grant stays deasserted for at least two cycles before it is asserted again.
- R6: At an arbitration point with no eligible request, the grant goes to the local master (index 9) if `park_own` is 1 and the local master is out of its gap. Otherwise every grant is deasserted.
- R7: `own_drive` is 1 exactly when the local master holds the grant and both `frame_n` and `irdy_n` are high.
- R8: During reset and on leaving reset, all grants are deasserted, `own_drive` is 0, and both rotation pointers start so that the search begins at index 0.
- R9: `prio_mask[i]` set to 1 puts agent i in the high group and set to 0 puts it in the low group. Bit 9 belongs to the local master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 9 | External requests, active-low |
| own_req_n | input | 1 | Local master request, active-low |
| frame_n | input | 1 | Frame, active-low; high marks an arbitration point |
| irdy_n | input | 1 | Initiator ready, active-low; with frame_n high it marks an idle bus |
| prio_mask | input | 10 | Group membership, 1 = high group; bit 9 = local master |
| park_own | input | 1 | 1 = park an idle bus on the local master |
| gnt_n | output | 10 | One-hot grants, active-low; bit 9 = local master |
| own_drive | output | 1 | Local master must drive address, command and parity |

## Verification
The assertions assume that requests, the mask and `park_own` are stable around the clock edge. They also assume that `frame_n` is the only thing that opens an arbitration point. They do not assume that requesters follow any protocol: an agent may drop or raise its request in any cycle. The stimulus changes every input only at the falling edge. It mixes directed sequences for parking, rotation, low-slot sharing and the grant gap with random requests, random frame and ready levels, and masks that are redrawn periodically.

// File: rtl/arb2_pkg.sv
package arb2_pkg;

  // Index of the first set bit after position `last`, wrapping over w bits; -1 if none.
  function automatic int rr_next(input logic [63:0] cand, input int last, input int w);
    int res;
    res = -1;
    for (int k = 1; k <= w; k++) begin
      int idx;
      idx = (last + k) % w;
      if (res < 0 && cand[idx]) res = idx;
    end
    return res;
  endfunction

endpackage

// File: rtl/arb2_rr_pick.sv
module arb2_rr_pick #(
  parameter int W  = 10,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  cand,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] win
);
  int res;

  always_comb begin
    res   = arb2_pkg::rr_next(64'(cand), int'(last), W);
    found = (res >= 0);
    win   = found ? IW'(res) : last;
  end
endmodule

// File: rtl/arb2_gap_timer.sv
module arb2_gap_timer #(
  parameter int GAP = 2,
  localparam int CW = $clog2(GAP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic held,
  input  logic held_next,
  output logic ready
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (held && !held_next) cnt <= CW'(GAP - 1);
    else if (cnt != '0)          cnt <= cnt - 1'b1;
  end

  assign ready = (cnt == '0);
endmodule

// File: rtl/arb2_top.sv
module arb2_top #(
  parameter int N_EXT = 9,
  parameter int GAP   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] req_n,
  input  logic             own_req_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic [N_EXT:0]   prio_mask,
  input  logic             park_own,
  output logic [N_EXT:0]   gnt_n,
  output logic             own_drive
);
  localparam int NA  = N_EXT + 1;
  localparam int OWN = N_EXT;
  localparam int NH  = NA + 1;
  localparam int HW  = $clog2(NH);
  localparam int LW  = $clog2(NA);

  logic [NA-1:0] req, ready, elig, lo_cand;
  logic [NH-1:0] hi_cand;
  logic [NA-1:0] gnt_q, gnt_d;
  logic [HW-1:0] ptr_hi, ptr_hi_d, hi_win;
  logic [LW-1:0] ptr_lo, ptr_lo_d, lo_win;
  logic          hi_found, lo_found;

  assign req     = {~own_req_n, ~req_n};
  assign elig    = req & ready;
  assign lo_cand = elig & ~prio_mask;
  assign hi_cand = {|lo_cand, elig & prio_mask};

  for (genvar i = 0; i < NA; i++) begin : g_gap
    arb2_gap_timer #(.GAP(GAP)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .held     (gnt_q[i]),
      .held_next(gnt_d[i]),
      .ready    (ready[i])
    );
  end

  arb2_rr_pick #(.W(NH), .IW(HW)) u_hi (
    .cand (hi_cand),
    .last (ptr_hi),
    .found(hi_found),
    .win  (hi_win)
  );

  arb2_rr_pick #(.W(NA), .IW(LW)) u_lo (
    .cand (lo_cand),
    .last (ptr_lo),
    .found(lo_found),
    .win  (lo_win)
  );

  always_comb begin
    gnt_d    = gnt_q;
    ptr_hi_d = ptr_hi;
    ptr_lo_d = ptr_lo;
    if (frame_n) begin
      if (hi_found) begin
        ptr_hi_d = hi_win;
        if (hi_win == HW'(NA)) begin
          gnt_d    = lo_found ? (NA'(1) << lo_win) : '0;
          ptr_lo_d = lo_win;
        end else begin
          gnt_d = NA'(1) << hi_win;
        end
      end else if (park_own && ready[OWN]) begin
        gnt_d = NA'(1) << OWN;
      end else begin
        gnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      ptr_hi <= HW'(NA);
      ptr_lo <= LW'(NA - 1);
    end else begin
      gnt_q  <= gnt_d;
      ptr_hi <= ptr_hi_d;
      ptr_lo <= ptr_lo_d;
    end
  end

  assign gnt_n     = ~gnt_q;
  assign own_drive = gnt_q[OWN] & frame_n & irdy_n;
endmodule

// File: rtl/arb2_chk.sv
module arb2_chk #(
  parameter int N_EXT = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_EXT-1:0] req_n,
  input logic             own_req_n,
  input logic             frame_n,
  input logic             park_own,
  input logic [N_EXT:0]   gnt_n
);
  localparam int OWN = N_EXT;

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> $stable(gnt_n));

  p_nopark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && (&req_n) && own_req_n && !park_own) |=> (&gnt_n));

  p_own_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gnt_n[OWN]) |-> $past(!own_req_n || park_own));

  for (genvar i = 0; i <= N_EXT; i++) begin : g_agent
    p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt_n[i]) |=> gnt_n[i]);
  end

  for (genvar i = 0; i < N_EXT; i++) begin : g_ext
    p_req_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gnt_n[i]) |-> $past(!req_n[i]));
  end
endmodule

bind arb2_top arb2_chk #(.N_EXT(N_EXT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_n    (req_n),
  .own_req_n(own_req_n),
  .frame_n  (frame_n),
  .park_own (park_own),
  .gnt_n    (gnt_n)
);

// File: tb/test_arb2_top.sv
module test_arb2_top;
  localparam int NE  = 9;
  localparam int NA  = 10;
  localparam int OWN = 9;
  localparam int GAP = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NE-1:0] req_n;
  logic          own_req_n, frame_n, irdy_n, park_own, own_drive;
  logic [NA-1:0] prio_mask, gnt_n;

  always #5 clk = ~clk;

  arb2_top #(.N_EXT(NE), .GAP(GAP)) i_arb2_top (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .own_req_n(own_req_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .prio_mask(prio_mask),
    .park_own(park_own), .gnt_n(gnt_n), .own_drive(own_drive)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int m_g     = -1;
  int m_hold[NA];
  int m_ph    = NA;
  int m_pl    = NA - 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: next grant index from model state and inputs (-1 = none).
  function automatic int ref_next(input logic [NA-1:0] rq, input bit fr,
                                  input logic [NA-1:0] mk, input bit pk,
                                  output int nph, output int npl);
    int ng;
    bit hit;
    ng = m_g; nph = m_ph; npl = m_pl;
    if (fr) begin
      ng = -1; hit = 0;
      for (int k = 1; k <= NA + 1; k++) begin
        int p;
        p = (m_ph + k) % (NA + 1);
        if (!hit && p < NA && mk[p] && rq[p] && m_hold[p] == 0) begin
          hit = 1; ng = p; nph = p;
        end else if (!hit && p == NA) begin
          for (int j = 1; j <= NA; j++) begin
            int q;
            q = (m_pl + j) % NA;
            if (!hit && !mk[q] && rq[q] && m_hold[q] == 0) begin
              hit = 1; ng = q; nph = NA; npl = q;
            end
          end
        end
      end
      if (!hit && pk && m_hold[OWN] == 0) ng = OWN;
    end
    return ng;
  endfunction

  task automatic step(input logic [NA-1:0] rq, input bit fr, input bit ir,
                      input logic [NA-1:0] mk, input bit pk, input string tag);
    int ng, nph, npl;
    logic [NA-1:0] exp_n;
    @(negedge clk);
    req_n = ~rq[NE-1:0]; own_req_n = ~rq[OWN];
    frame_n = fr; irdy_n = ir; prio_mask = mk; park_own = pk;
    ng = ref_next(rq, fr, mk, pk, nph, npl);
    @(posedge clk);
    #1;
    exp_n = (ng < 0) ? '1 : ~(NA'(1) << ng);
    check(gnt_n === exp_n, tag, 32'(gnt_n), 32'(exp_n));
    check($countones(~gnt_n) <= 1, "R1 one-hot", 32'(gnt_n), 32'(exp_n));
    check(own_drive === ((ng == OWN) && fr && ir), "R7 own_drive",
          32'(own_drive), 32'((ng == OWN) && fr && ir));
    for (int i = 0; i < NA; i++) begin
      if (m_g == i && ng != i)  m_hold[i] = GAP - 1;
      else if (m_hold[i] > 0)   m_hold[i] = m_hold[i] - 1;
    end
    m_g = ng; m_ph = nph; m_pl = npl;
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [NA-1:0] mk, rq;
    bit pk;
    void'($urandom(32'd1234));
    for (int i = 0; i < NA; i++) m_hold[i] = 0;
    rst_n = 1'b0; req_n = '1; own_req_n = 1'b1; frame_n = 1'b1; irdy_n = 1'b1;
    prio_mask = 10'h200; park_own = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(gnt_n === '1, "R8 reset grants", 32'(gnt_n), 32'h3ff);
    check(own_drive === 1'b0, "R8 reset own_drive", 32'(own_drive), 0);
    rst_n = 1'b1;

    // R6 parking on and off
    repeat (2) step(10'h000, 1, 1, 10'h200, 1, "R6 park on own");
    repeat (3) step(10'h000, 1, 1, 10'h200, 0, "R6 no park");
    // R3 high-group rotation
    repeat (8) step(10'h007, 1, 1, 10'h207, 0, "R3 high rotation");
    // R2 hold while frame low
    step(10'h001, 0, 0, 10'h207, 0, "R2 hold frame low");
    step(10'h002, 0, 1, 10'h207, 0, "R2 hold frame low");
    step(10'h000, 0, 0, 10'h207, 1, "R2 hold frame low");
    // R4 low group shares one slot
    repeat (14) step(10'h03f, 1, 1, 10'h203, 0, "R4 low slot");
    // R9 mask selects group
    repeat (6) step(10'h011, 1, 1, 10'h010, 0, "R9 mask high bit4");
    repeat (6) step(10'h011, 1, 1, 10'h001, 0, "R9 mask high bit0");
    // R5 gap after deassertion
    step(10'h001, 1, 1, 10'h3ff, 0, "R5 gap");
    step(10'h000, 1, 1, 10'h3ff, 0, "R5 gap");
    repeat (4) step(10'h001, 1, 1, 10'h3ff, 0, "R5 gap");
    step(10'h200, 1, 0, 10'h3ff, 0, "R7 own granted busy");
    step(10'h200, 1, 1, 10'h3ff, 0, "R7 own granted idle");

    // random traffic
    mk = 10'h200; pk = 1'b1;
    for (int n = 0; n < 600; n++) begin
      if (n % 50 == 0) begin
        mk = NA'($urandom);
        pk = 1'($urandom);
      end
      rq = NA'($urandom) & NA'($urandom);
      step(rq, ($urandom % 4) != 0, 1'($urandom), mk, pk, "R3 R4 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule